// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Start-up Sequencing

This block keeps a 4M x 4 dynamic memory refreshed and brings it up correctly after reset. It first waits out the power-up pause. It then runs a fixed number of CAS-before-RAS (CBR) refresh cycles. Only after these has finished does it raise a ready flag that the access path uses to open its port. During normal operation an interval timer adds one owed refresh every fixed period. The period is chosen so that every row is covered inside the retention window. Because the memory counts rows itself during a CBR cycle, no row address is ever driven.

The scheduler shares the strobe lines with the access sequencer. It asks for them with a request line and acts once the grant input is high. A granted refresh drops every CAS lane first, then drops RAS, and holds both low for the required width. It then raises both together and keeps them high for the precharge time before it gives the lines back. Refreshes that fall due while the grant is withheld are kept in a saturating backlog. A deep backlog raises an urgent flag. If neither side has pulsed RAS for longer than the idle limit, the memory is treated as uninitialized and the start-up cycles are run again.

All timing counts are derived from a clock-frequency parameter. Minimum widths round up. The refresh interval rounds down.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is applied, and on the first cycle after it, RAS and all CAS lanes are high (inactive) and `ref_req`, `ref_urgent` and `init_done` are all 0.
- R2: `ref_req` stays 0 for PWRUP_US*CLK_MHZ cycles after reset is released. It first reads 1 on cycle number PWRUP_US*CLK_MHZ, counting the first clock with reset released as cycle 1.
- R3: After the pause, exactly INIT_CYCLES CBR cycles run. `init_done` rises on the clock edge that ends the precharge of the last of them.
- R4: A CBR cycle starts on the clock edge after a cycle in which a refresh is owed, the lines are free and `ref_gnt` is 1. In that cycle:
  - all CAS lanes go low first;
  - ceil(CSR_NS*CLK_MHZ/1000) cycles later, RAS goes low;
  - RAS stays low for the larger of ceil(RAS_NS*CLK_MHZ/1000) and ceil(CHR_NS*CLK_MHZ/1000) cycles;
  - RAS and CAS then rise together and stay high for ceil(RP_NS*CLK_MHZ/1000) cycles;
  - `ref_req` stays 1 until that precharge ends.
- R5: Once `init_done` is 1, one refresh becomes owed every floor(REFRESH_US*CLK_MHZ/ROWS) cycles. With the grant held high, successive RAS falls are that many cycles apart.
- R6: Owed refreshes accumulate while the grant is low, up to BACKLOG_MAX. Further ones are dropped. `ref_urgent` is 1 exactly while the backlog is at least URGENT_AT.
- R7: If, while `init_done` is 1, no RAS activity occurs for IDLE_US*CLK_MHZ cycles, then:
  - `init_done` falls;
  - the backlog is cleared;
  - INIT_CYCLES CBR cycles are run again, without a new power-up pause.

  RAS activity means either a refresh cycle in progress or `acc_ras_act` high.
- R8: A single-cycle pulse on `acc_ras_act` restarts the idle measurement, so that no re-initialization happens earlier than IDLE_US*CLK_MHZ cycles after it.
- R9: No CBR cycle starts while `ref_gnt` is 0. A cycle already started runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_gnt | input | 1 | Strobe lines granted to the scheduler |
| acc_ras_act | input | 1 | Pulse from the access sequencer when it runs a RAS cycle |
| ref_req | output | 1 | Request for the strobe lines (refresh owed or running) |
| ref_urgent | output | 1 | Backlog at or above the urgent threshold |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | CAS_W | Column strobes, all lanes driven together, active low |
| init_done | output | 1 | Memory initialized; gates the access port |

## Verification
The assertions take for granted that `ref_gnt` is only meaningful at the start of a refresh, and that the access sequencer leaves the strobe lines alone while `ref_req` is high. The bench lowers and raises the grant at arbitrary cycles, including inside a running refresh. It relies on the sequencer ignoring the grant once a cycle has begun. `acc_ras_act` is only pulsed for a single cycle while the grant is withheld, which is the case the idle measurement must handle. Scaled-down time parameters let the power-up pause, backlog saturation and the idle re-initialization all occur inside a short run.

// File: rtl/rfsh_pkg.sv
// Shared types and timing helpers for the DRAM refresh scheduler.
// Assumes all times are given as whole ns/us and the clock as whole MHz.
package rfsh_pkg;

    typedef enum logic [1:0] {PH_PWRUP, PH_INIT, PH_RUN} phase_t;

    typedef enum logic [1:0] {SQ_IDLE, SQ_LEAD, SQ_ACT, SQ_PRE} seq_t;

    // Minimum time in ns converted to clock cycles, rounded up, at least one.
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Free-running interval timer: pulses tick once every PERIOD cycles while
// run is high, restarting from zero whenever run is low.
// Assumes PERIOD >= 1.
module rfsh_interval_timer #(
    parameter int PERIOD = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(PERIOD + 1);

    logic [W-1:0] cnt;

    // Count cycles of the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == W'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == W'(PERIOD - 1));

    generate
        if (PERIOD > 1) begin : g_spacing
            // R5: two owed refreshes are never added on adjacent cycles
            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rfsh_backlog.sv
// Saturating count of refreshes owed. add and sub on the same cycle cancel.
// Assumes URGENT_AT is between 1 and MAX.
module rfsh_backlog #(
    parameter int MAX       = 8,
    parameter int URGENT_AT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic add,
    input  logic sub,
    output logic pending,
    output logic urgent
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt;

    // Track owed refreshes, dropping additions beyond MAX.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (add && !sub && cnt != CW'(MAX))
            cnt <= cnt + 1'b1;
        else if (sub && !add && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign pending = (cnt != '0);
    assign urgent  = (cnt >= CW'(URGENT_AT));

    // R6: the backlog moves by at most one per cycle unless cleared
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

    // R6: the urgent flag never shows without an owed refresh
    a_r6_urgent_owed: assert property (@(posedge clk) disable iff (!rst_n)
        urgent |-> pending);

endmodule

// File: rtl/rfsh_cbr_seq.sv
// Drives one CAS-before-RAS refresh per start pulse: CAS lanes low for
// N_LEAD cycles, then RAS also low for N_ACT cycles, then both high for
// N_PRE cycles. start is only honoured while idle.
module rfsh_cbr_seq #(
    parameter int N_LEAD = 1,
    parameter int N_ACT  = 5,
    parameter int N_PRE  = 3,
    parameter int CAS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             ras_active,
    output logic             ras_n,
    output logic [CAS_W-1:0] cas_n
);
    import rfsh_pkg::*;

    localparam int NMAX = max2(N_LEAD, max2(N_ACT, N_PRE));
    localparam int CW   = $clog2(NMAX + 1);
    localparam int LW   = CW + 1;

    seq_t          st;
    logic [CW-1:0] left;
    logic          cas_low;

    // Step through lead, active and precharge phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SQ_IDLE;
            left <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    st   <= SQ_LEAD;
                    left <= CW'(N_LEAD - 1);
                end
                SQ_LEAD: if (left == '0) begin
                    st   <= SQ_ACT;
                    left <= CW'(N_ACT - 1);
                end else left <= left - 1'b1;
                SQ_ACT: if (left == '0) begin
                    st   <= SQ_PRE;
                    left <= CW'(N_PRE - 1);
                end else left <= left - 1'b1;
                SQ_PRE: if (left == '0) st <= SQ_IDLE;
                        else left <= left - 1'b1;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy       = (st != SQ_IDLE);
    assign done       = (st == SQ_PRE) && (left == '0);
    assign ras_active = (st == SQ_ACT);
    assign ras_n      = !ras_active;
    assign cas_low    = (st == SQ_LEAD) || (st == SQ_ACT);

    generate
        for (genvar i = 0; i < CAS_W; i++) begin : g_lane
            assign cas_n[i] = !cas_low;
        end
    endgenerate

    // Checker state: length of the current RAS low and high stretches.
    logic [LW-1:0] lo_len, hi_len;

    // Measure strobe widths for the width assertions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_len <= '0;
            hi_len <= LW'(N_PRE);
        end else if (!ras_n) begin
            hi_len <= '0;
            lo_len <= (lo_len == '1) ? lo_len : lo_len + 1'b1;
        end else begin
            lo_len <= '0;
            hi_len <= (hi_len == '1) ? hi_len : hi_len + 1'b1;
        end
    end

    // R4: every CAS lane is already low in the cycle before RAS falls
    a_r4_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == '0));

    // R4: RAS low stretch meets the minimum width
    a_r4_ras_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (lo_len >= LW'(N_ACT)));

    // R4: RAS precharge meets the minimum before the next fall
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_len >= LW'(N_PRE)));

    // R4: CAS is released together with RAS
    a_r4_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n == '1));

endmodule

// File: rtl/dram_refresh_sched.sv
// Refresh scheduler for a 4M x 4 DRAM: power-up pause, start-up CBR cycles,
// distributed CBR refresh with backlog, idle-triggered re-initialization.
// Assumes the access sequencer leaves the strobe lines alone while ref_req
// is high and pulses acc_ras_act whenever it runs its own RAS cycle.
module dram_refresh_sched #(
    parameter int CLK_MHZ     = 100,
    parameter int PWRUP_US    = 200,
    parameter int REFRESH_US  = 32000,
    parameter int ROWS        = 2048,
    parameter int IDLE_US     = 8000,
    parameter int INIT_CYCLES = 8,
    parameter int BACKLOG_MAX = 8,
    parameter int URGENT_AT   = 4,
    parameter int CSR_NS      = 5,
    parameter int CHR_NS      = 8,
    parameter int RAS_NS      = 50,
    parameter int RP_NS       = 30,
    parameter int CAS_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    input  logic             acc_ras_act,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             dram_ras_n,
    output logic [CAS_W-1:0] dram_cas_n,
    output logic             init_done
);
    import rfsh_pkg::*;

    localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
    localparam int REFI_CYC  = (REFRESH_US * CLK_MHZ) / ROWS;
    localparam int IDLE_CYC  = IDLE_US * CLK_MHZ;
    localparam int N_LEAD    = ns_to_cycles(CSR_NS, CLK_MHZ);
    localparam int N_ACT     = max2(ns_to_cycles(RAS_NS, CLK_MHZ), ns_to_cycles(CHR_NS, CLK_MHZ));
    localparam int N_PRE     = ns_to_cycles(RP_NS, CLK_MHZ);
    localparam int PW_W      = $clog2(PWRUP_CYC + 1);
    localparam int ID_W      = $clog2(IDLE_CYC + 1);
    localparam int IN_W      = $clog2(INIT_CYCLES + 1);

    phase_t          phase;
    logic [PW_W-1:0] pw_cnt;
    logic [IN_W-1:0] init_left;
    logic [ID_W-1:0] idle_cnt;
    logic            seq_busy, seq_done, seq_ras, seq_start;
    logic            tick, bl_pending, pending, reinit;

    assign pending   = ((phase == PH_INIT) && (init_left != '0)) || bl_pending;
    assign seq_start = !seq_busy && pending && ref_gnt;
    assign reinit    = (phase == PH_RUN) && !acc_ras_act && !seq_busy
                       && (idle_cnt == ID_W'(IDLE_CYC - 1));

    rfsh_interval_timer #(.PERIOD(REFI_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_RUN),
        .tick  (tick)
    );

    rfsh_backlog #(.MAX(BACKLOG_MAX), .URGENT_AT(URGENT_AT)) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (reinit),
        .add     (tick),
        .sub     (seq_done && phase == PH_RUN),
        .pending (bl_pending),
        .urgent  (ref_urgent)
    );

    rfsh_cbr_seq #(.N_LEAD(N_LEAD), .N_ACT(N_ACT), .N_PRE(N_PRE), .CAS_W(CAS_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seq_start),
        .busy       (seq_busy),
        .done       (seq_done),
        .ras_active (seq_ras),
        .ras_n      (dram_ras_n),
        .cas_n      (dram_cas_n)
    );

    // Sequence power-up pause, start-up refreshes and normal running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_PWRUP;
            pw_cnt    <= '0;
            init_left <= '0;
        end else begin
            case (phase)
                PH_PWRUP: if (pw_cnt == PW_W'(PWRUP_CYC - 1)) begin
                    phase     <= PH_INIT;
                    init_left <= IN_W'(INIT_CYCLES);
                end else pw_cnt <= pw_cnt + 1'b1;
                PH_INIT: if (seq_done) begin
                    init_left <= init_left - 1'b1;
                    if (init_left == IN_W'(1)) phase <= PH_RUN;
                end
                PH_RUN: if (reinit) begin
                    phase     <= PH_INIT;
                    init_left <= IN_W'(INIT_CYCLES);
                end
                default: phase <= PH_PWRUP;
            endcase
        end
    end

    // Measure cycles since the last RAS activity from either side.
    always_ff @(posedge clk) begin
        if (!rst_n || phase != PH_RUN)
            idle_cnt <= '0;
        else if (acc_ras_act || seq_busy || reinit)
            idle_cnt <= '0;
        else
            idle_cnt <= idle_cnt + 1'b1;
    end

    assign ref_req   = seq_busy || pending;
    assign init_done = (phase == PH_RUN);

    // R2: nothing is requested or strobed during the power-up pause
    a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PWRUP) |-> (!ref_req && dram_cas_n == '1));

    // R3: ready only follows the end of a refresh cycle
    a_r3_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(seq_done));

    // R4: strobes are only driven while the lines are requested
    a_r4_strobe_under_req: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cas_n != '1 || seq_ras) |-> ref_req);

    // R6: urgency only exists in normal running
    a_r6_urgent_running: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> init_done);

    // R7: losing ready always leaves start-up refreshes owed
    a_r7_reinit_requests: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_done) |-> ref_req);

    // R8: an access RAS pulse keeps the memory ready on the next cycle
    a_r8_access_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && acc_ras_act) |=> init_done);

    // R9: a refresh begins only after a granted cycle
    a_r9_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n[0]) |-> $past(ref_gnt));

endmodule

// File: tb/dram_refresh_sched_test.sv
// Bench: behavioural reference model compared on every clock plus
// scenario checks for pause, start-up, interval, backlog and idle rules.
module dram_refresh_sched_test;

    localparam int MHZ    = 100;
    localparam int B_PWR  = 2 * MHZ;                 // 200
    localparam int B_REFI = (10 * MHZ) / 16;         // 62, rounded down
    localparam int B_IDLE = 20 * MHZ;                // 2000
    localparam int B_LEAD = 1;                       // 5 ns
    localparam int B_ACT  = 5;                       // max(50 ns, 8 ns)
    localparam int B_PRE  = 3;                       // 30 ns
    localparam int B_INIT = 8;
    localparam int B_MAX  = 8;
    localparam int B_URG  = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       ref_gnt = 0;
    logic       acc_ras_act = 0;
    logic       ref_req, ref_urgent, dram_ras_n, init_done;
    logic [3:0] dram_cas_n;

    int checks = 0;
    int errors = 0;

    dram_refresh_sched #(
        .CLK_MHZ(MHZ), .PWRUP_US(2), .REFRESH_US(10), .ROWS(16), .IDLE_US(20),
        .INIT_CYCLES(B_INIT), .BACKLOG_MAX(B_MAX), .URGENT_AT(B_URG),
        .CSR_NS(5), .CHR_NS(8), .RAS_NS(50), .RP_NS(30), .CAS_W(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .acc_ras_act(acc_ras_act),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .init_done(init_done)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state: phase 0 pause, 1 start-up, 2 running;
    // strobe step 0 idle, 1 lead, 2 RAS low, 3 precharge.
    int  m_ph = 0, m_pw = 0, m_il = 0, m_bl = 0, m_tm = 0, m_id = 0, m_sq = 0, m_sl = 0;
    bit  live = 0;

    always @(posedge clk) begin
        bit busy, done, pend, tick, hit;
        if (!rst_n) begin
            m_ph = 0; m_pw = 0; m_il = 0; m_bl = 0; m_tm = 0; m_id = 0; m_sq = 0; m_sl = 0;
            live = 1;
        end else begin
            busy = (m_sq != 0);
            done = (m_sq == 3 && m_sl == 1);
            pend = (m_ph == 1 && m_il > 0) || (m_ph == 2 && m_bl > 0);
            tick = (m_ph == 2 && m_tm == B_REFI - 1);
            hit  = (m_ph == 2 && !acc_ras_act && !busy && m_id == B_IDLE - 1);
            if (m_sq == 0) begin
                if (pend && ref_gnt) begin m_sq = 1; m_sl = B_LEAD; end
            end else if (m_sl > 1) m_sl--;
            else if (m_sq == 1) begin m_sq = 2; m_sl = B_ACT; end
            else if (m_sq == 2) begin m_sq = 3; m_sl = B_PRE; end
            else m_sq = 0;
            if (m_ph == 0) begin
                if (m_pw == B_PWR - 1) begin m_ph = 1; m_il = B_INIT; end
                else m_pw++;
            end else if (m_ph == 1) begin
                m_tm = 0; m_id = 0;
                if (done) begin m_il--; if (m_il == 0) m_ph = 2; end
            end else if (hit) begin
                m_ph = 1; m_il = B_INIT; m_bl = 0; m_tm = 0; m_id = 0;
            end else begin
                if (tick && !done) m_bl = (m_bl < B_MAX) ? m_bl + 1 : B_MAX;
                else if (done && !tick) m_bl = (m_bl > 0) ? m_bl - 1 : 0;
                m_tm = tick ? 0 : m_tm + 1;
                m_id = (acc_ras_act || busy) ? 0 : m_id + 1;
            end
        end
    end

    // Per-cycle comparison away from the active edge, plus edge counting.
    int cyc = 0;
    int ras_falls = 0;
    int last_fall_cyc = 0;
    logic prev_ras = 1;

    always @(negedge clk) begin
        if (live) begin
            bit pend;
            cyc++;
            pend = (m_ph == 1 && m_il > 0) || (m_ph == 2 && m_bl > 0);
            chk("R4 ras_n", int'(dram_ras_n), (m_sq == 2) ? 0 : 1);
            chk("R4 cas_n", int'(dram_cas_n), (m_sq == 1 || m_sq == 2) ? 0 : 15);
            chk("R2 ref_req", int'(ref_req), (m_sq != 0 || pend) ? 1 : 0);
            chk("R6 ref_urgent", int'(ref_urgent), (m_bl >= B_URG) ? 1 : 0);
            chk("R3 init_done", int'(init_done), (m_ph == 2) ? 1 : 0);
            if (prev_ras && !dram_ras_n) begin
                ras_falls++;
                last_fall_cyc = cyc;
            end
            prev_ras = dram_ras_n;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL R3 watchdog expired actual=%0d expected=<%0d", wd, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        while (!init_done) @(negedge clk);
    endtask

    initial begin
        int n, f0, c1, c2;
        // R1: reset state
        step(3);
        chk("R1 ras_n", int'(dram_ras_n), 1);
        chk("R1 cas_n", int'(dram_cas_n), 15);
        chk("R1 ref_req", int'(ref_req), 0);
        chk("R1 init_done", int'(init_done), 0);
        rst_n = 1;
        ref_gnt = 1;
        ras_falls = 0;

        // R2: first request exactly after the pause
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_req);
        chk("R2 pause length", n, B_PWR);

        // R3: start-up cycle count before ready
        wait_ready();
        chk("R3 start-up cycles", ras_falls, B_INIT);

        // R5: spacing of distributed refreshes with grant held
        f0 = ras_falls;
        while (ras_falls == f0) @(negedge clk);
        c1 = last_fall_cyc;
        while (ras_falls == f0 + 1) @(negedge clk);
        c2 = last_fall_cyc;
        chk("R5 interval", c2 - c1, B_REFI);

        // R9: no refresh starts while grant is low; R6: backlog grows
        @(negedge clk); ref_gnt = 0;
        step(20);
        f0 = ras_falls;
        step(680);
        chk("R9 no strobe without grant", ras_falls, f0);
        chk("R6 urgent after backlog", int'(ref_urgent), 1);

        // R6: saturated backlog drains once grant returns
        ref_gnt = 1;
        step(200);
        chk("R6 drained", int'(ref_urgent), 0);

        // R8: access pulse restarts idle measurement
        ref_gnt = 0;
        step(1500);
        acc_ras_act = 1;
        step(1);
        acc_ras_act = 0;
        step(1500);
        chk("R8 still ready", int'(init_done), 1);

        // R7: idle limit exceeded, then start-up cycles repeat
        step(600);
        chk("R7 ready dropped", int'(init_done), 0);
        chk("R7 refresh requested", int'(ref_req), 1);
        f0 = ras_falls;
        ref_gnt = 1;
        wait_ready();
        chk("R7 repeated start-up cycles", ras_falls - f0, B_INIT);

        // R1: reset in the middle of running
        step(37);
        rst_n = 0;
        step(2);
        chk("R1 ras_n after reset", int'(dram_ras_n), 1);
        chk("R1 init_done after reset", int'(init_done), 0);
        chk("R1 ref_urgent after reset", int'(ref_urgent), 0);
        rst_n = 1;
        step(10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule